// File: doc/BRIEF.md
# Dual-Rate SPI Bit Clock Generator

This block paces the bits of an SPI transfer from a faster reference clock. Each bit lasts a whole number of reference cycles, the divisor. The divisor is chosen per bit from two programmable fields: one applies to bits that are being written and the other to bits that are being read. The transfer engine gives a one-cycle start pulse, keeps the read/write phase indicator valid for each upcoming bit, and raises a stop request when the current bit is to be the last one.

Each bit is made of two halves. In the setup half the SPI clock sits at its idle level, and the block gives a setup strobe on the last cycle of that half. In the sample half the clock sits at the opposite level, and the block gives a sample strobe on the last cycle of that half. When a divisor is odd, the setup half is one cycle longer than the sample half. Data shifting and chip-select control belong to the transfer engine. The engine uses the two strobes to drive and capture data.

Top module: `spi_bitclk_gen`

## Requirements
- R1: While reset is held (rst_n low), `sclk` equals `cpol`, and `setup_stb` and `sample_stb` are both low.
- R2: Whenever no transfer is running, `sclk` equals `cpol`. This holds for both polarity values.
- R3: The divisor of a bit is its field value plus 2, so a field value of 0 gives 2 cycles and a field value of 255 gives 257 cycles. A bit lasts exactly that many reference cycles. The setup half lasts ceil(d/2) cycles with `sclk` equal to `cpol`. The sample half lasts floor(d/2) cycles with `sclk` equal to the inverse of `cpol`.
- R4: `setup_stb` is a single-cycle pulse on the last cycle of each setup half. `sample_stb` is a single-cycle pulse on the last cycle of each sample half. The two strobes are never high together, and they alternate.
- R5: For an odd divisor, the extra reference cycle goes to the setup half. For example, d=5 gives 3 setup cycles and 2 sample cycles.
- R6: A bit uses `wr_div_m2` when `phase_rd` is 0 and `rd_div_m2` when `phase_rd` is 1. `phase_rd` is sampled on the clock edge where the bit begins: the start edge, or the edge that ends the previous sample half.
- R7: A change to either divisor field during a bit does not alter that bit. The change first applies to the next bit that begins.
- R8: A `stop` pulse seen during a transfer lets the current bit finish. After the sample strobe of that bit, the block returns to idle and gives no further strobes. A `stop` pulse while idle has no effect.
- R9: A `start` pulse while a transfer is running is ignored, and the bit timing continues unchanged.
- R10: After `start` is sampled high while idle, the first setup half begins in the next cycle. The first setup strobe therefore comes ceil(d/2) cycles after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_div_m2 | input | DIV_W | Write-bit divisor minus 2 |
| rd_div_m2 | input | DIV_W | Read-bit divisor minus 2 |
| cpol | input | 1 | Idle level of the SPI clock |
| start | input | 1 | One-cycle pulse that begins a transfer |
| phase_rd | input | 1 | 1 when the next bit is a read bit, 0 when it is a write bit |
| stop | input | 1 | Request to end the transfer after the current bit |
| sclk | output | 1 | SPI clock pin level |
| setup_stb | output | 1 | Pulse on the last cycle of a setup half |
| sample_stb | output | 1 | Pulse on the last cycle of a sample half |

## Verification
The assertions assume that `cpol` only changes while the block is idle, because the level checks compare `sclk` with the current `cpol`. They also assume that `start` and `stop` are pulses driven between clock edges. The stimulus changes `cpol` only between transfers, when no bit is in flight. It drives every control and divisor change on the falling edge, so each input value is settled before the rising edge that samples it. It also gives `phase_rd` its value for the next bit in the cycle where the previous sample strobe appears.

// File: rtl/spi_bclk_pkg.sv
package spi_bclk_pkg;
  typedef enum logic {
    HALF_SETUP  = 1'b0,
    HALF_SAMPLE = 1'b1
  } half_e;
endpackage

// File: rtl/spi_bclk_divsel.sv
// Picks the divisor for the next bit and splits it into two half lengths.
// Both lengths are given minus one, ready to load into a down-counter.
module spi_bclk_divsel #(
  parameter int DIV_W = 8
) (
  input  logic [DIV_W-1:0] wr_m2,
  input  logic [DIV_W-1:0] rd_m2,
  input  logic             rd_sel,
  output logic [DIV_W-1:0] setup_m1,
  output logic [DIV_W-1:0] sample_m1
);
  logic [DIV_W-1:0] sel_m2;
  logic [DIV_W:0]   sum_up;

  assign sel_m2 = rd_sel ? rd_m2 : wr_m2;
  // ceil(d/2)-1 = (m2+1)>>1 ; floor(d/2)-1 = m2>>1, where d = m2+2
  assign sum_up    = {1'b0, sel_m2} + {{DIV_W{1'b0}}, 1'b1};
  assign setup_m1  = sum_up[DIV_W:1];
  assign sample_m1 = sel_m2 >> 1;
endmodule

// File: rtl/spi_bclk_timer.sv
// Half-period sequencer: counts the setup and sample halves of each bit.
module spi_bclk_timer
  import spi_bclk_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic [CNT_W-1:0] setup_m1,
  input  logic [CNT_W-1:0] sample_m1,
  output logic             run,
  output logic             in_sample,
  output logic             setup_stb,
  output logic             sample_stb
);
  logic             run_q;
  logic             stop_pend_q;
  half_e            half_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] samp_len_q;
  logic             half_end;

  assign half_end   = run_q && (cnt_q == '0);
  assign setup_stb  = half_end && (half_q == HALF_SETUP);
  assign sample_stb = half_end && (half_q == HALF_SAMPLE);
  assign run        = run_q;
  assign in_sample  = run_q && (half_q == HALF_SAMPLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q       <= 1'b0;
      stop_pend_q <= 1'b0;
      half_q      <= HALF_SETUP;
      cnt_q       <= '0;
      samp_len_q  <= '0;
    end else if (!run_q) begin
      stop_pend_q <= 1'b0;
      if (start) begin
        run_q      <= 1'b1;
        half_q     <= HALF_SETUP;
        cnt_q      <= setup_m1;
        samp_len_q <= sample_m1;
      end
    end else begin
      if (stop) stop_pend_q <= 1'b1;
      if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end else if (half_q == HALF_SETUP) begin
        half_q <= HALF_SAMPLE;
        cnt_q  <= samp_len_q;
      end else if (stop || stop_pend_q) begin
        run_q       <= 1'b0;
        stop_pend_q <= 1'b0;
        half_q      <= HALF_SETUP;
        cnt_q       <= '0;
      end else begin
        half_q     <= HALF_SETUP;
        cnt_q      <= setup_m1;
        samp_len_q <= sample_m1;
      end
    end
  end
endmodule

// File: rtl/spi_bitclk_gen.sv
module spi_bitclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] wr_div_m2,
  input  logic [DIV_W-1:0] rd_div_m2,
  input  logic             cpol,
  input  logic             start,
  input  logic             phase_rd,
  input  logic             stop,
  output logic             sclk,
  output logic             setup_stb,
  output logic             sample_stb
);
  logic [DIV_W-1:0] setup_m1;
  logic [DIV_W-1:0] sample_m1;
  logic             run_w;
  logic             in_sample_w;

  spi_bclk_divsel #(.DIV_W(DIV_W)) u_divsel (
    .wr_m2    (wr_div_m2),
    .rd_m2    (rd_div_m2),
    .rd_sel   (phase_rd),
    .setup_m1 (setup_m1),
    .sample_m1(sample_m1)
  );

  spi_bclk_timer #(.CNT_W(DIV_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .stop      (stop),
    .setup_m1  (setup_m1),
    .sample_m1 (sample_m1),
    .run       (run_w),
    .in_sample (in_sample_w),
    .setup_stb (setup_stb),
    .sample_stb(sample_stb)
  );

  assign sclk = cpol ^ in_sample_w;
endmodule

// File: rtl/spi_bclk_chk.sv
module spi_bclk_chk (
  input logic clk,
  input logic rst_n,
  input logic cpol,
  input logic start,
  input logic stop,
  input logic run,
  input logic sclk,
  input logic setup_stb,
  input logic sample_stb
);
  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(setup_stb && sample_stb));
  // R4
  setup_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setup_stb |=> !setup_stb);
  // R4
  sample_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb);
  // R2
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (sclk == cpol));
  // R3
  sample_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> (sclk != cpol));
  // R3
  setup_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setup_stb |-> (sclk == cpol));
  // R8
  stop_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && stop) |=> !run);
  // R10
  start_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !run) |=> run);
endmodule

bind spi_bitclk_gen spi_bclk_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpol      (cpol),
  .start     (start),
  .stop      (stop),
  .run       (run_w),
  .sclk      (sclk),
  .setup_stb (setup_stb),
  .sample_stb(sample_stb)
);

// File: tb/tb_spi_bitclk_gen.sv
module tb_spi_bitclk_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] wr_div_m2 = '0;
  logic [7:0] rd_div_m2 = '0;
  logic       cpol = 1'b0;
  logic       start = 1'b0;
  logic       phase_rd = 1'b0;
  logic       stop = 1'b0;
  logic       sclk, setup_stb, sample_stb;

  int unsigned cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;

  typedef struct {
    bit    is_sample;
    int    at;
    string tag;
  } ev_t;
  ev_t exp_q[$];

  spi_bitclk_gen dut (
    .clk(clk), .rst_n(rst_n), .wr_div_m2(wr_div_m2), .rd_div_m2(rd_div_m2),
    .cpol(cpol), .start(start), .phase_rd(phase_rd), .stop(stop),
    .sclk(sclk), .setup_stb(setup_stb), .sample_stb(sample_stb)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  // monitor: compare each strobe with the next expected item
  always @(negedge clk) begin
    if (rst_n && (setup_stb || sample_stb)) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8", "unexpected strobe at cycle", int'(cyc), -1);
      end else begin
        ev_t e;
        e = exp_q.pop_front();
        chk(e.is_sample == sample_stb, e.tag, "strobe kind", int'(sample_stb), int'(e.is_sample));
        chk(e.at == int'(cyc), e.tag, "strobe cycle", int'(cyc), e.at);
        chk(sclk == (cpol ^ sample_stb), e.tag, "sclk level", int'(sclk), int'(cpol ^ sample_stb));
      end
    end
  end

  task automatic wait_cyc(int target);
    while (int'(cyc) != target) @(negedge clk);
  endtask

  // driver: one transfer of nw write bits then nr read bits
  task automatic xfer(int nw, int nr, int wm2, int rm2, int new_wm2, bit poke, string tag);
    int n = nw + nr;
    int ends[$];
    int t, c;
    @(negedge clk);
    wr_div_m2 = 8'(wm2);
    rd_div_m2 = 8'(rm2);
    phase_rd  = (nw == 0);
    start     = 1'b1;
    c = int'(cyc);
    t = c;
    for (int i = 0; i < n; i++) begin
      int m2, d;
      ev_t e;
      if (i >= nw) m2 = rm2;
      else if (i == 0 || new_wm2 < 0) m2 = wm2;
      else m2 = new_wm2;
      d = m2 + 2;
      e.is_sample = 1'b0; e.at = t + (d + 1) / 2; e.tag = tag;
      exp_q.push_back(e);
      e.is_sample = 1'b1; e.at = t + d;
      exp_q.push_back(e);
      t = t + d;
      ends.push_back(t);
    end
    @(negedge clk);
    start = 1'b0;
    if (new_wm2 >= 0) wr_div_m2 = 8'(new_wm2);
    if (n == 1) begin
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
    end
    if (poke) begin
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i + 1 < n; i++) begin
      wait_cyc(ends[i]);
      phase_rd = (i + 1 >= nw);
      if (i + 2 == n) begin
        @(negedge clk);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
      end
    end
    wait_cyc(ends[n-1] + 2);
    chk(sclk == cpol, "R8", "idle sclk after stop", int'(sclk), int'(cpol));
    chk(exp_q.size() == 0, tag, "missing strobes", exp_q.size(), 0);
  endtask

  initial begin
    #3_000_000;
    chk(1'b0, "WD", "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sclk == 1'b0, "R1", "sclk in reset", int'(sclk), 0);
    chk(!setup_stb && !sample_stb, "R1", "strobes in reset", int'(setup_stb | sample_stb), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 idle level follows polarity
    cpol = 1'b1;
    @(negedge clk);
    chk(sclk == 1'b1, "R2", "idle sclk cpol=1", int'(sclk), 1);
    xfer(2, 1, 2, 1, -1, 1'b0, "R2");
    cpol = 1'b0;
    @(negedge clk);
    chk(sclk == 1'b0, "R2", "idle sclk cpol=0", int'(sclk), 0);
    // R3 minimum divisor and a mid-size one
    xfer(3, 0, 0, 0, -1, 1'b0, "R3");
    xfer(2, 0, 6, 0, -1, 1'b0, "R3");
    // R5 odd divisors
    xfer(2, 0, 3, 0, -1, 1'b0, "R5");
    xfer(0, 2, 0, 1, -1, 1'b0, "R5");
    // R6 write bits then read bits with different divisors
    xfer(2, 2, 2, 5, -1, 1'b0, "R6");
    // R7 divisor change inside the first bit
    xfer(3, 0, 4, 0, 1, 1'b0, "R7");
    // R9 start while running is ignored
    xfer(2, 0, 4, 0, -1, 1'b1, "R9");
    // R8 stop while idle has no effect
    @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    repeat (2) @(negedge clk);
    chk(sclk == cpol && !setup_stb && !sample_stb, "R8", "idle after idle stop", int'(sclk), int'(cpol));
    // R10 single bit: first setup half right after start
    xfer(1, 0, 1, 0, -1, 1'b0, "R10");
    xfer(0, 1, 0, 255, -1, 1'b0, "R3");
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule